// File: doc/BRIEF.md
# Paired-Instruction Fetch Sequencer

This block is the fetch front end of a simple accumulator processor whose memory words are 40 bits wide. Each word carries two 20-bit instructions, and each instruction is an 8-bit opcode followed by a 12-bit operand address. The sequencer reads one word from a synchronous word memory. It hands out the upper (left) instruction first and keeps the lower (right) instruction in an internal buffer. The right instruction is handed out next without another memory read. The program counter always names a word, meaning an instruction pair. It advances once the right instruction of that pair has been handed out.

Decoded instructions go to an execute stage through a valid/ready handshake. An offered instruction stays fixed until the execute stage takes it. The execute stage can redirect fetch to any word. The redirect also selects whether execution resumes at the left or the right instruction of that word. A redirect empties the buffer, so the next instruction always comes from a fresh memory read.

Top module: `pairword_fetch_seq`

## Requirements
- R1: An issued instruction's fields come from the fetched word as follows. The left instruction uses bits [39:32] as opcode and [31:20] as address. The right instruction uses bits [19:12] as opcode and [11:0] as address.
- R2: From a left entry point, instructions are issued in the order left of word P, right of word P, left of word P+1, and so on. The right instruction of a word is issued without a memory read.
- R3: A memory read for a new word presents the current program counter on mem_addr. The counter advances by one only after the right instruction of the word has been issued.
- R4: mem_rd is high for exactly one cycle per read. The word is captured from mem_rdata in the following cycle. When the instruction comes from that read, out_valid rises in the third cycle after the mem_rd cycle.
- R5: When the next instruction is already buffered, out_valid rises in the second cycle after the cycle in which the previous instruction was accepted.
- R6: While out_valid is high and out_ready is low, out_valid, out_opcode and out_addr do not change, unless a redirect is applied.
- R7: A redirect with redir_right low loads the counter with redir_target and discards the buffered instruction. The next read is at the target, and its left instruction is issued first.
- R8: A redirect with redir_right high makes the next read go to the target. The right instruction of that word is issued, and then fetch continues with the left instruction of target+1.
- R9: During reset mem_rd and out_valid are low. After reset the first read is at word 0, and its left instruction is issued first.
- R10: The 12-bit counter wraps from 4095 to 0 after the right instruction of word 4095.
- R11: A redirect applied while an instruction is offered but not accepted withdraws that instruction. out_valid is low in the next cycle, and the withdrawn instruction is never issued.
- R12: A redirect applied in the same cycle as an accepted transfer leaves that transfer complete. The redirect then takes effect for the following instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 12 | Word address for the memory read |
| mem_rd | output | 1 | Read strobe; data is expected on mem_rdata one cycle later |
| mem_rdata | input | 40 | Word returned by the memory |
| redir_valid | input | 1 | Redirect request for this cycle |
| redir_target | input | 12 | Word address to resume at |
| redir_right | input | 1 | 1: resume at the right instruction of the target word |
| out_valid | output | 1 | An instruction is offered |
| out_ready | input | 1 | Execute stage accepts the offered instruction |
| out_opcode | output | 8 | Opcode of the offered instruction |
| out_addr | output | 12 | Operand address of the offered instruction |

## Verification
Each result has a fixed latency. An instruction that needs a memory read is offered three cycles after the mem_rd pulse. A buffered instruction is offered two cycles after the previous one is accepted. A redirect silences both outputs in the very next cycle. The bench drives inputs a fraction of a cycle after the falling edge and samples all ports shortly after that, so each observation reflects exactly one register update. On each rising out_valid, the bench measures the gap back to the last read or the last accepted transfer and compares it with the latency above. Read addresses and issued instructions are compared in order against queues filled from a model of the program-counter walk.

// File: rtl/pwf_pkg.sv
package pwf_pkg;

    localparam int DEF_OPC_W = 8;
    localparam int DEF_ADR_W = 12;

    // Number of instructions packed into one memory word.
    localparam int SLOTS_PER_WORD = 2;

    typedef enum logic [2:0] {
        ST_PICK  = 3'd0,   // choose buffered instruction or start a read
        ST_READ  = 3'd1,   // strobe the memory
        ST_WAIT  = 3'd2,   // capture the returned word
        ST_SPLIT = 3'd3,   // pick a half of the captured word
        ST_ISSUE = 3'd4    // offer the instruction to execute
    } fetch_state_e;

    // Slot index of each half inside the word, slot 1 being the upper half.
    typedef enum logic {
        SLOT_RIGHT = 1'b0,
        SLOT_LEFT  = 1'b1
    } slot_e;

    function automatic logic state_is(input fetch_state_e cur, input fetch_state_e want);
        return cur == want;
    endfunction

endpackage

// File: rtl/pwf_pc_reg.sv
module pwf_pc_reg #(
    parameter int ADR_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_en,
    input  logic [ADR_W-1:0] load_val,
    input  logic             step_en,
    output logic [ADR_W-1:0] pc
);
    localparam logic [ADR_W-1:0] STEP = ADR_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
        end else if (load_en) begin
            pc <= load_val;
        end else if (step_en) begin
            pc <= pc + STEP;
        end
    end
endmodule

// File: rtl/pwf_ibuf.sv
module pwf_ibuf #(
    parameter int INSN_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fill_en,
    input  logic [INSN_W-1:0] fill_val,
    input  logic              drop_en,
    output logic              held,
    output logic [INSN_W-1:0] insn
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held <= 1'b0;
            insn <= '0;
        end else if (drop_en) begin
            held <= 1'b0;
        end else if (fill_en) begin
            held <= 1'b1;
            insn <= fill_val;
        end
    end
endmodule

// File: rtl/pairword_fetch_seq.sv
module pairword_fetch_seq
    import pwf_pkg::*;
#(
    parameter int OPC_W = DEF_OPC_W,
    parameter int ADR_W = DEF_ADR_W
) (
    input  logic             clk,
    input  logic             rst,
    output logic [ADR_W-1:0] mem_addr,
    output logic             mem_rd,
    input  logic [2*(OPC_W+ADR_W)-1:0] mem_rdata,
    input  logic             redir_valid,
    input  logic [ADR_W-1:0] redir_target,
    input  logic             redir_right,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [OPC_W-1:0] out_opcode,
    output logic [ADR_W-1:0] out_addr
);
    localparam int INSN_W = OPC_W + ADR_W;
    localparam int WORD_W = SLOTS_PER_WORD * INSN_W;

    fetch_state_e state;
    logic              take_right;
    logic [OPC_W-1:0]  ir;
    logic [ADR_W-1:0]  mar;
    logic [WORD_W-1:0] mbr;

    logic [ADR_W-1:0]  pc;
    logic              buf_held;
    logic [INSN_W-1:0] buf_insn;

    // Split the captured word into its instruction slots.
    logic [INSN_W-1:0] slot [SLOTS_PER_WORD];
    for (genvar s = 0; s < SLOTS_PER_WORD; s++) begin : g_slot
        assign slot[s] = mbr[s*INSN_W +: INSN_W];
    end

    logic [INSN_W-1:0] left_insn;
    logic [INSN_W-1:0] right_insn;
    assign left_insn  = slot[SLOT_LEFT];
    assign right_insn = slot[SLOT_RIGHT];

    logic in_pick, in_split;
    assign in_pick  = state_is(state, ST_PICK);
    assign in_split = state_is(state, ST_SPLIT);

    logic pc_step, buf_fill, buf_drop;
    assign pc_step  = !redir_valid && ((in_pick && buf_held) || (in_split && take_right));
    assign buf_fill = !redir_valid && in_split && !take_right;
    assign buf_drop = redir_valid || (in_pick && buf_held);

    pwf_pc_reg #(.ADR_W(ADR_W)) u_pc (
        .clk      (clk),
        .rst      (rst),
        .load_en  (redir_valid),
        .load_val (redir_target),
        .step_en  (pc_step),
        .pc       (pc)
    );

    pwf_ibuf #(.INSN_W(INSN_W)) u_ibuf (
        .clk      (clk),
        .rst      (rst),
        .fill_en  (buf_fill),
        .fill_val (right_insn),
        .drop_en  (buf_drop),
        .held     (buf_held),
        .insn     (buf_insn)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_PICK;
            take_right <= 1'b0;
            ir         <= '0;
            mar        <= '0;
            mbr        <= '0;
        end else if (redir_valid) begin
            state      <= ST_PICK;
            take_right <= redir_right;
        end else begin
            unique case (state)
                ST_PICK: begin
                    if (buf_held) begin
                        ir    <= buf_insn[INSN_W-1 -: OPC_W];
                        mar   <= buf_insn[ADR_W-1:0];
                        state <= ST_ISSUE;
                    end else begin
                        mar   <= pc;
                        state <= ST_READ;
                    end
                end
                ST_READ: begin
                    state <= ST_WAIT;
                end
                ST_WAIT: begin
                    mbr   <= mem_rdata;
                    state <= ST_SPLIT;
                end
                ST_SPLIT: begin
                    if (take_right) begin
                        ir         <= right_insn[INSN_W-1 -: OPC_W];
                        mar        <= right_insn[ADR_W-1:0];
                        take_right <= 1'b0;
                    end else begin
                        ir  <= left_insn[INSN_W-1 -: OPC_W];
                        mar <= left_insn[ADR_W-1:0];
                    end
                    state <= ST_ISSUE;
                end
                ST_ISSUE: begin
                    if (out_ready) begin
                        state <= ST_PICK;
                    end
                end
                default: begin
                    state <= ST_PICK;
                end
            endcase
        end
    end

    assign mem_addr   = mar;
    assign mem_rd     = state_is(state, ST_READ);
    assign out_valid  = state_is(state, ST_ISSUE);
    assign out_opcode = ir;
    assign out_addr   = mar;

endmodule

// File: rtl/pwf_checker.sv
module pwf_checker #(
    parameter int OPC_W = 8,
    parameter int ADR_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             mem_rd,
    input logic             redir_valid,
    input logic             out_valid,
    input logic             out_ready,
    input logic [OPC_W-1:0] out_opcode,
    input logic [ADR_W-1:0] out_addr
);
    // R6: a stalled offer is frozen
    assert_stall_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && !redir_valid)
        |=> (out_valid && $stable(out_opcode) && $stable(out_addr)));

    // R4: the read strobe is a single-cycle pulse
    assert_read_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> !mem_rd);

    // R7: a redirect leaves the next cycle quiet on both sides
    assert_redirect_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        redir_valid |=> (!out_valid && !mem_rd));

    // R5: an accepted offer is never followed directly by another offer
    assert_accept_gap_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready) |=> !out_valid);

    // R9: the first cycle out of reset is idle
    assert_reset_idle_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && !mem_rd));
endmodule

bind pairword_fetch_seq pwf_checker #(.OPC_W(OPC_W), .ADR_W(ADR_W)) u_pwf_checker (
    .clk         (clk),
    .rst         (rst),
    .mem_rd      (mem_rd),
    .redir_valid (redir_valid),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_opcode  (out_opcode),
    .out_addr    (out_addr)
);

// File: tb/tb_pairword_fetch_seq.sv
module tb_pairword_fetch_seq;
    localparam int OPC_W  = 8;
    localparam int ADR_W  = 12;
    localparam int WORD_W = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;   // 50 MHz

    logic [ADR_W-1:0]  mem_addr;
    logic              mem_rd;
    logic [WORD_W-1:0] mem_rdata;
    logic              redir_valid = 1'b0;
    logic [ADR_W-1:0]  redir_target = '0;
    logic              redir_right = 1'b0;
    logic              out_valid;
    logic              out_ready;
    logic [OPC_W-1:0]  out_opcode;
    logic [ADR_W-1:0]  out_addr;

    pairword_fetch_seq #(.OPC_W(OPC_W), .ADR_W(ADR_W)) dut (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_rdata(mem_rdata), .redir_valid(redir_valid),
        .redir_target(redir_target), .redir_right(redir_right),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_opcode(out_opcode), .out_addr(out_addr)
    );

    // Program image, computed per address.
    function automatic logic [7:0]  lop (input logic [11:0] a); return a[7:0] ^ 8'h3C; endfunction
    function automatic logic [11:0] ladr(input logic [11:0] a); return a ^ 12'h0F0; endfunction
    function automatic logic [7:0]  rop (input logic [11:0] a); return a[7:0] ^ 8'hC3; endfunction
    function automatic logic [11:0] radr(input logic [11:0] a); return ~a; endfunction
    function automatic logic [WORD_W-1:0] word_at(input logic [11:0] a);
        return {lop(a), ladr(a), rop(a), radr(a)};
    endfunction

    always_ff @(posedge clk) begin
        if (mem_rd) mem_rdata <= word_at(mem_addr);
    end

    typedef struct packed { logic [7:0] op; logic [11:0] adr; } item_t;
    item_t       exp_q[$];
    string       exp_tag_q[$];
    logic [11:0] rd_q[$];
    string       rd_tag_q[$];

    int total = 0, bad = 0, accepts = 0, cyc = 0;
    int stall_mode = 0;
    bit finished = 0;
    logic [11:0] m_pc = '0;
    int m_side = 0;   // 0 left needs read, 1 right buffered, 2 right needs read

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    initial forever begin @(posedge clk); cyc++; end

    // Ready pattern
    initial begin
        out_ready = 1'b0;
        forever begin
            @(negedge clk); #1;
            case (stall_mode)
                0:       out_ready = 1'b1;
                1:       out_ready = (cyc % 3 == 2);
                default: out_ready = 1'b0;
            endcase
        end
    end

    // Monitor
    int   last_rd = -10, last_fire = -10;
    bit   prev_valid = 0, prev_stall = 0;
    item_t held;
    initial forever begin
        @(negedge clk); #3;
        if (!rst) begin
            if (mem_rd) begin
                last_rd = cyc;
                if (rd_q.size() > 0) begin
                    logic [11:0] a;
                    string t;
                    a = rd_q.pop_front();
                    t = rd_tag_q.pop_front();
                    check(mem_addr == a, t, "R3 read address", mem_addr, a);
                end
            end
            if (out_valid && !prev_valid) begin
                if (last_rd > last_fire)
                    check(cyc - last_rd == 3, "R4", "read-to-offer cycles", cyc - last_rd, 3);
                else
                    check(cyc - last_fire == 2, "R5", "accept-to-offer cycles", cyc - last_fire, 2);
            end
            if (prev_stall && out_valid) begin
                check({out_opcode, out_addr} == held, "R6", "stalled offer stable",
                      {out_opcode, out_addr}, held);
            end
            if (out_valid && !out_ready) held = {out_opcode, out_addr};
            prev_stall = out_valid && !out_ready && !redir_valid;
            if (out_valid && out_ready) begin
                last_fire = cyc;
                accepts++;
                if (exp_q.size() == 0) begin
                    check(0, "R2 R11", "unexpected issue", {out_opcode, out_addr}, 0);
                end else begin
                    item_t e;
                    string t;
                    e = exp_q.pop_front();
                    t = exp_tag_q.pop_front();
                    check(out_opcode == e.op, t, "R1 opcode", out_opcode, e.op);
                    check(out_addr == e.adr, t, "R1 address", out_addr, e.adr);
                end
            end
            prev_valid = out_valid;
        end
    end

    task automatic push_items(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            case (m_side)
                0: begin
                    rd_q.push_back(m_pc); rd_tag_q.push_back(tag);
                    exp_q.push_back({lop(m_pc), ladr(m_pc)}); exp_tag_q.push_back(tag);
                    m_side = 1;
                end
                1: begin
                    exp_q.push_back({rop(m_pc), radr(m_pc)}); exp_tag_q.push_back(tag);
                    m_pc = m_pc + 12'd1; m_side = 0;
                end
                default: begin
                    rd_q.push_back(m_pc); rd_tag_q.push_back(tag);
                    exp_q.push_back({rop(m_pc), radr(m_pc)}); exp_tag_q.push_back(tag);
                    m_pc = m_pc + 12'd1; m_side = 0;
                end
            endcase
        end
    endtask

    // Run n instructions; optionally redirect on the cycle the last one is taken (R12).
    task automatic stream(input int n, input string tag, input bit redir,
                          input logic [11:0] tgt, input bit tright);
        int goal;
        goal = accepts + n;
        push_items(n, tag);
        forever begin
            @(negedge clk); #2;
            if (redir) begin
                if (accepts == goal - 1 && out_valid && out_ready) begin
                    redir_valid = 1'b1; redir_target = tgt; redir_right = tright;
                    @(negedge clk); #2;
                    redir_valid = 1'b0;
                    m_pc = tgt; m_side = tright ? 2 : 0;
                    break;
                end
            end else if (accepts >= goal) begin
                break;
            end
        end
    endtask

    task automatic withdraw(input logic [11:0] tgt);
        stall_mode = 2;
        forever begin @(negedge clk); #2; if (out_valid) break; end
        repeat (3) @(negedge clk);
        #2;
        check(out_valid == 1'b1, "R6", "offer held under stall", out_valid, 1);
        redir_valid = 1'b1; redir_target = tgt; redir_right = 1'b0;
        @(negedge clk); #2;
        redir_valid = 1'b0;
        check(out_valid == 1'b0, "R11", "offer withdrawn after redirect", out_valid, 0);
        stall_mode = 0;
        m_pc = tgt; m_side = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #2;
        check(out_valid == 1'b0, "R9", "out_valid in reset", out_valid, 0);
        check(mem_rd == 1'b0, "R9", "mem_rd in reset", mem_rd, 0);
        rst = 1'b0;

        stream(1, "R9", 0, '0, 0);
        stream(4, "R2", 0, '0, 0);
        stall_mode = 1;
        stream(6, "R6", 0, '0, 0);
        stall_mode = 0;
        stream(1, "R12", 1, 12'h123, 0);
        stream(3, "R7", 1, 12'h2A7, 1);
        stream(3, "R8", 1, 12'hFFF, 0);
        stream(4, "R10", 0, '0, 0);
        withdraw(12'h050);
        stream(2, "R11", 0, '0, 0);

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R2", "all expected instructions issued", exp_q.size(), 0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule